// File: doc/BRIEF.md
# Cascaded LED Driver Frame Sequencer

This block is the host side of a daisy-chained LED driver string that uses the shift clock itself as the grayscale reference. A frame runs in four phases. First, the block takes `NUM_DEV` packets of `PKT_BITS` bits from a valid/ready source and shifts them out back to back on `sclk`/`sdat`, MSB first. The packet meant for the device farthest down the chain is taken first. Second, the block parks the clock low long enough for every device to generate its internal latch pulse. Third, it waits a fixed setup gap. Fourth, it runs `GS_PULSES` clock pulses with data held low to pace one display period.

Each phase of `sclk` lasts a number of system clocks set by the `div` input, which is sampled when a frame begins. While `run` is held high, frames follow one another without any further command. `busy` marks a frame in progress, and `done` pulses once as each frame closes. The block always places the fixed write command in the top six bits of every packet. The remaining bits, which include the mode flags the drivers expect, pass through unchanged from the source.

Top module: `led_chain_seq`

## Requirements
- R1: After reset and whenever no frame is in progress, `busy`, `sclk`, `sdat`, `pkt_ready` and `done` are all 0.
- R2: With `run` high while idle, a frame starts and accepts exactly `NUM_DEV` packets through `pkt_valid`/`pkt_ready`. The packet accepted first is shifted out first.
- R3: Each packet is sent MSB first, bit [PKT_BITS-1] on the first rising edge of `sclk`. One frame contains exactly NUM_DEV*PKT_BITS + GS_PULSES rising edges.
- R4: Bits [PKT_BITS-1:PKT_BITS-6] of every transmitted packet are 6'b100101, whatever the source supplies. All other bits are sent as supplied.
- R5: `sdat` changes only while `sclk` is low, so it is stable throughout every high phase.
- R6: Let h = max(`div`,1), with `div` sampled when the frame starts. Each low and each high phase of `sclk` lasts h system clocks, so consecutive rising edges are 2h apart. `div` = 0 behaves as 1, and changing `div` mid-frame has no effect on that frame.
- R7: When the source keeps `pkt_valid` high, the first bit of each following packet rises exactly 2h cycles after the last bit of the previous packet.
- R8: After the last data bit, `sclk` stays high for h cycles and then low. The next rising edge comes exactly 20h + SETUP_CYC cycles after the last data rising edge, which is at least 16h + SETUP_CYC.
- R9: The grayscale phase sends `GS_PULSES` rising edges, all with `sdat` = 0.
- R10: `done` is high for exactly one cycle per frame, after the last grayscale pulse has fallen, and `busy` is low on the next cycle.
- R11: While `run` stays high, a new frame starts after each `done` with no further command, taking the next `NUM_DEV` packets from the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start frames and keep repeating them while high |
| div | input | DIV_W | System clocks per half period of `sclk` (0 acts as 1) |
| pkt_valid | input | 1 | Source has a packet on `pkt_data` |
| pkt_data | input | PKT_BITS | Packet for the next device, farthest device first |
| pkt_ready | output | 1 | Packet is taken on this cycle when `pkt_valid` is high |
| sclk | output | 1 | Shift and grayscale clock to the chain |
| sdat | output | 1 | Serial data to the chain |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The rising-edge count and grayscale-data properties assume that no frame is cut short by reset. The bench asserts reset only once, at the start. The back-to-back timing of R7 holds only if the source never withholds a packet at a packet boundary, so the bench supplies random packets from a pre-filled pool and keeps `pkt_valid` high throughout. Divider values are drawn from a small range, so frames stay short enough to run several of them, including one where `div` changes in mid-frame.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_LATCH,
        ST_SETUP,
        ST_GS,
        ST_DONE
    } seq_state_e;

    // write command placed at the top of every packet
    localparam logic [5:0] WRITE_CMD = 6'b100101;
    localparam int CMD_W = 6;

    // low hold after the data burst, in half periods of sclk
    localparam int LATCH_HALVES = 18;

endpackage

// File: rtl/led_seq_halftimer.sv
module led_seq_halftimer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d    = q;
        tick = en && (q.cnt == half - DIV_W'(1));
        if (!en || tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/led_seq_shreg.sv
module led_seq_shreg
    import led_seq_pkg::*;
#(
    parameter int W = 224
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);

    typedef struct packed {
        logic [W-1:0] sr;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.sr = din;
            d.sr[W-1 -: CMD_W] = WRITE_CMD;
        end else if (shift) begin
            d.sr = {q.sr[W-2:0], 1'b0};
        end
    end

    assign msb = q.sr[W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/led_chain_seq.sv
module led_chain_seq
    import led_seq_pkg::*;
#(
    parameter int NUM_DEV   = 4,
    parameter int PKT_BITS  = 224,
    parameter int DIV_W     = 8,
    parameter int GS_PULSES = 65536,
    parameter int SETUP_CYC = 150
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [DIV_W-1:0]    div,
    input  logic                pkt_valid,
    input  logic [PKT_BITS-1:0] pkt_data,
    output logic                pkt_ready,
    output logic                sclk,
    output logic                sdat,
    output logic                busy,
    output logic                done
);

    localparam int BIT_W  = $clog2(PKT_BITS);
    localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int GS_W   = (GS_PULSES > 1) ? $clog2(GS_PULSES) : 1;
    localparam int WAIT_W = $clog2(LATCH_HALVES * (2 ** DIV_W) + SETUP_CYC + 1);

    typedef struct packed {
        seq_state_e         st;
        logic               ph;
        logic               sclk;
        logic [BIT_W-1:0]   bitn;
        logic [DEV_W-1:0]   dev;
        logic [GS_W-1:0]    gs;
        logic [WAIT_W-1:0]  wt;
        logic [WAIT_W-1:0]  lim;
        logic [DIV_W-1:0]   half;
    } regs_t;

    regs_t d, q;

    logic tick;
    logic tmr_en;
    logic sh_load;
    logic sh_shift;
    logic sh_msb;
    logic [DIV_W-1:0] eff_div;

    assign eff_div = (div == '0) ? DIV_W'(1) : div;
    assign tmr_en  = (q.st == ST_SHIFT) || (q.st == ST_GS);

    led_seq_halftimer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tmr_en),
        .half  (q.half),
        .tick  (tick)
    );

    led_seq_shreg #(.W(PKT_BITS)) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .shift (sh_shift),
        .din   (pkt_data),
        .msb   (sh_msb)
    );

    always_comb begin
        d         = q;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        pkt_ready = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.sclk = 1'b0;
                if (run) begin
                    d.half = eff_div;
                    d.lim  = WAIT_W'(LATCH_HALVES) * WAIT_W'(eff_div) - WAIT_W'(1);
                    d.dev  = DEV_W'(NUM_DEV - 1);
                    d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                pkt_ready = 1'b1;
                if (pkt_valid) begin
                    sh_load = 1'b1;
                    d.bitn  = BIT_W'(PKT_BITS - 1);
                    d.ph    = 1'b0;
                    d.st    = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.ph) begin
                        d.sclk = 1'b1;
                        d.ph   = 1'b1;
                    end else if (q.bitn != '0) begin
                        sh_shift = 1'b1;
                        d.bitn   = q.bitn - BIT_W'(1);
                        d.sclk   = 1'b0;
                        d.ph     = 1'b0;
                    end else if (q.dev != '0) begin
                        // next packet follows with no idle period
                        pkt_ready = 1'b1;
                        if (pkt_valid) begin
                            sh_load = 1'b1;
                            d.dev   = q.dev - DEV_W'(1);
                            d.bitn  = BIT_W'(PKT_BITS - 1);
                            d.sclk  = 1'b0;
                            d.ph    = 1'b0;
                        end
                    end else begin
                        d.sclk = 1'b0;
                        d.wt   = '0;
                        d.st   = ST_LATCH;
                    end
                end
            end
            ST_LATCH: begin
                if (q.wt == q.lim) begin
                    d.wt = '0;
                    d.st = ST_SETUP;
                end else begin
                    d.wt = q.wt + WAIT_W'(1);
                end
            end
            ST_SETUP: begin
                if (q.wt == WAIT_W'(SETUP_CYC - 1)) begin
                    d.ph = 1'b0;
                    d.gs = GS_W'(GS_PULSES - 1);
                    d.st = ST_GS;
                end else begin
                    d.wt = q.wt + WAIT_W'(1);
                end
            end
            ST_GS: begin
                if (tick) begin
                    if (!q.ph) begin
                        d.sclk = 1'b1;
                        d.ph   = 1'b1;
                    end else if (q.gs != '0) begin
                        d.gs   = q.gs - GS_W'(1);
                        d.sclk = 1'b0;
                        d.ph   = 1'b0;
                    end else begin
                        d.sclk = 1'b0;
                        d.st   = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.half <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    assign sclk = q.sclk;
    assign sdat = (q.st == ST_SHIFT) && sh_msb;
    assign busy = (q.st != ST_IDLE);
    assign done = (q.st == ST_DONE);

endmodule

// File: rtl/led_chain_seq_chk.sv
module led_chain_seq_chk #(
    parameter int NUM_DEV   = 4,
    parameter int PKT_BITS  = 224,
    parameter int GS_PULSES = 65536
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic sdat,
    input logic busy,
    input logic done,
    input logic pkt_ready,
    input logic pkt_valid
);

    localparam int DATA_RISES  = NUM_DEV * PKT_BITS;
    localparam int TOTAL_RISES = DATA_RISES + GS_PULSES;

    logic        sclk_prev;
    logic [31:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            rise_cnt  <= '0;
        end else begin
            sclk_prev <= sclk;
            if (done) begin
                rise_cnt <= '0;
            end else if (sclk && !sclk_prev) begin
                rise_cnt <= rise_cnt + 32'd1;
            end
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdat && !done));

    a_r2_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_ready || (pkt_valid && pkt_ready)) |-> busy);

    a_r5_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdat) |-> !sclk);

    a_r3_edges_per_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rise_cnt == 32'(TOTAL_RISES)));

    a_r9_gs_data_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_cnt > 32'(DATA_RISES)) |-> !sdat);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !sclk));

endmodule

bind led_chain_seq led_chain_seq_chk #(
    .NUM_DEV   (NUM_DEV),
    .PKT_BITS  (PKT_BITS),
    .GS_PULSES (GS_PULSES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .sdat      (sdat),
    .busy      (busy),
    .done      (done),
    .pkt_ready (pkt_ready),
    .pkt_valid (pkt_valid)
);

// File: tb/led_chain_seq_test.sv
module led_chain_seq_test;

    localparam int NDEV  = 3;
    localparam int PBITS = 224;
    localparam int DW    = 4;
    localparam int GSN   = 20;
    localparam int SETUP = 30;
    localparam int DATA  = NDEV * PBITS;
    localparam int TOT   = DATA + GSN;
    localparam int POOL  = 64;
    localparam int MAXR  = 2048;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b0;
    logic [DW-1:0]    div = '0;
    logic             pkt_valid = 1'b0;
    logic [PBITS-1:0] pkt_data;
    logic             pkt_ready, sclk, sdat, busy, done;

    logic [PBITS-1:0] pkts [POOL];
    int idx = 0;

    int checks = 0;
    int errors = 0;
    bit hung = 1'b0;

    int cyc = 0;
    int nrise = 0;
    int rise_t [MAXR];
    bit rise_b [MAXR];
    int donecnt = 0;
    int done_run_bad = 0;
    int r5_bad = 0;
    bit prev_sclk = 1'b0;
    bit prev_sdat = 1'b0;
    bit prev_done = 1'b0;

    always #5 clk = ~clk;

    led_chain_seq #(
        .NUM_DEV(NDEV), .PKT_BITS(PBITS), .DIV_W(DW),
        .GS_PULSES(GSN), .SETUP_CYC(SETUP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_ready(pkt_ready),
        .sclk(sclk), .sdat(sdat), .busy(busy), .done(done)
    );

    assign pkt_data = pkts[idx % POOL];

    always @(posedge clk) begin
        if (pkt_valid && pkt_ready) idx <= idx + 1;
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (sclk && !prev_sclk && nrise < MAXR) begin
                rise_t[nrise] = cyc;
                rise_b[nrise] = sdat;
                nrise = nrise + 1;
            end
            if (sclk && prev_sclk && (sdat != prev_sdat)) r5_bad = r5_bad + 1;
            if (done) donecnt = donecnt + 1;
            if (done && prev_done) done_run_bad = done_run_bad + 1;
        end
        prev_sclk = sclk;
        prev_sdat = sdat;
        prev_done = done;
    end

    function automatic logic [PBITS-1:0] forced(input logic [PBITS-1:0] p);
        logic [PBITS-1:0] r;
        r = p;
        r[PBITS-1 -: 6] = 6'b100101;
        return r;
    endfunction

    function automatic logic [PBITS-1:0] rand_pkt();
        logic [PBITS-1:0] r;
        for (int i = 0; i < PBITS / 32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frames(input int dv, input int nf, input bit change_div, input int dv2);
        int base, eff, t0, lim;
        base = idx;
        eff = (dv == 0) ? 1 : dv;
        @(negedge clk);
        nrise = 0; donecnt = 0; r5_bad = 0; done_run_bad = 0;
        div = DW'(dv);
        run = 1'b1;
        if (change_div) begin
            wait_cyc(40);
            div = DW'(dv2);
        end
        t0 = cyc;
        lim = 40000;
        while (donecnt < nf && !hung) begin
            @(negedge clk);
            if (cyc - t0 > lim) hung = 1'b1;
        end
        if (hung) begin
            chk(1'b0, "R10", "watchdog expired waiting for done", donecnt, nf);
            return;
        end
        run = 1'b0;
        wait_cyc(4);
        chk(busy == 1'b0, "R10", "busy after last done", busy, 0);
        chk(done_run_bad == 0, "R10", "done longer than one cycle", done_run_bad, 0);
        chk(nrise == nf * TOT, "R3", "rising edges in run", nrise, nf * TOT);
        chk(idx - base == nf * NDEV, "R2", "packets accepted", idx - base, nf * NDEV);
        chk(r5_bad == 0, "R5", "sdat changed while sclk high", r5_bad, 0);
        if (nrise != nf * TOT) return;
        for (int f = 0; f < nf; f++) begin
            int o, bad_bits, bad_per, bad_gs_per, bad_gs_dat, gap, mism_at;
            o = f * TOT;
            bad_bits = 0; bad_per = 0; bad_gs_per = 0; bad_gs_dat = 0; mism_at = -1;
            for (int k = 0; k < NDEV; k++) begin
                logic [PBITS-1:0] e;
                e = forced(pkts[(base + f * NDEV + k) % POOL]);
                for (int j = 0; j < PBITS; j++) begin
                    if (rise_b[o + k * PBITS + j] != e[PBITS-1-j]) begin
                        bad_bits++;
                        if (mism_at < 0) mism_at = k * PBITS + j;
                    end
                end
            end
            chk(bad_bits == 0, "R4", "data bits vs forced header packets", bad_bits, 0);
            for (int i = 1; i < DATA; i++)
                if (rise_t[o+i] - rise_t[o+i-1] != 2 * eff) bad_per++;
            chk(bad_per == 0, "R6", "data rise spacing off 2h", bad_per, 0);
            chk(rise_t[o+PBITS] - rise_t[o+PBITS-1] == 2 * eff, "R7",
                "packet boundary spacing", rise_t[o+PBITS] - rise_t[o+PBITS-1], 2 * eff);
            gap = rise_t[o+DATA] - rise_t[o+DATA-1];
            chk(gap == 20 * eff + SETUP && gap >= 16 * eff + SETUP, "R8",
                "latch plus setup gap", gap, 20 * eff + SETUP);
            for (int i = DATA + 1; i < TOT; i++)
                if (rise_t[o+i] - rise_t[o+i-1] != 2 * eff) bad_gs_per++;
            chk(bad_gs_per == 0, "R9", "grayscale spacing", bad_gs_per, 0);
            for (int i = DATA; i < TOT; i++)
                if (rise_b[o+i]) bad_gs_dat++;
            chk(bad_gs_dat == 0, "R9", "grayscale data high", bad_gs_dat, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h1ed5_0c4a));
        for (int i = 0; i < POOL; i++) pkts[i] = rand_pkt();
        pkts[0][PBITS-1 -: 6] = 6'b011010;
        pkts[1][PBITS-1 -: 6] = 6'b000000;
        pkts[2][PBITS-1 -: 6] = 6'b111111;
        wait_cyc(5);
        chk(!busy && !sclk && !sdat && !pkt_ready && !done, "R1", "outputs in reset",
            {busy, sclk, sdat, pkt_ready, done}, 0);
        rst_n = 1'b1;
        wait_cyc(5);
        chk(!busy && !sclk && !sdat && !pkt_ready && !done, "R1", "outputs idle after reset",
            {busy, sclk, sdat, pkt_ready, done}, 0);
        pkt_valid = 1'b1;
        wait_cyc(3);
        chk(!busy && !pkt_ready && idx == 0, "R1", "valid without run ignored", idx, 0);

        // R2 R3 R4: directed smallest divider
        if (!hung) run_frames(1, 1, 1'b0, 0);
        // R6: zero divider acts as one
        if (!hung) run_frames(0, 1, 1'b0, 0);
        // R6: divider changed in mid-frame has no effect
        if (!hung) run_frames(3, 1, 1'b1, 1);
        // R11: run held high gives two frames back to back
        if (!hung) run_frames(2, 2, 1'b0, 0);
        // random dividers
        for (int r = 0; r < 2; r++) begin
            if (!hung) run_frames(1 + int'($urandom % 6), 1, 1'b0, 0);
        end
        if (!hung) begin
            wait_cyc(3);
            chk(!busy && !sclk && !sdat && !pkt_ready, "R1", "idle at end",
                {busy, sclk, sdat, pkt_ready}, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL R10 global watchdog: actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule